// File: doc/BRIEF.md
# Eleven-Level Carrier-Stacked PWM Modulator

This block turns a sinusoidal reference into a signed staircase command for an eleven-level inverter. A phase accumulator addresses a quarter-wave sine table, and the table sample is scaled by a modulation index. The scaled reference is then compared with ten triangular carriers stacked on top of one another. The result is a level index from -5 to +5. A downstream stage maps that index to switch gates.

The carriers share one up/down counter. A per-band inversion flag sets the relative phase of each band, chosen from three arrangements: all bands in phase, the bands below zero inverted against those above, or every band inverted against its neighbour. The arrangement can be changed at run time. A change is adopted only when a new carrier period begins. A one-cycle strobe marks the output sample that belongs to the first point of each carrier period.

Top module: `lsp_modulator`

## Requirements
- R1: While `rst` is high, `level` is 0 and `period_stb` is 0. Phase, carrier position and arrangement (band-aligned) are cleared.
- R2: While `en` is low, `level` and `period_stb` are 0 one cycle later. Phase and carrier position return to their start, and the arrangement is loaded from `arr_sel`.
- R3: `level` equals the number of upper carriers (bands 5..9) that the reference strictly exceeds, minus the number of lower carriers (bands 0..4) that the reference is strictly below. It stays within -5..+5 and reaches both +5 and -5 over a fundamental at full index.
- R4: Each carrier is a triangle of period 2·CAR_HALF cycles. It is at its minimum at the first point of the period and at its maximum CAR_HALF at mid-period. Band k (0..9) spans (k-5)·CAR_HALF to (k-4)·CAR_HALF.
- R5: `arr_sel` = 2'b00 puts all ten bands in phase. 2'b11 behaves the same way.
- R6: `arr_sel` = 2'b01 keeps bands 5..9 in phase and runs bands 0..4 inverted (shifted by 180°).
- R7: `arr_sel` = 2'b10 inverts every odd band, so each band is 180° from its neighbours. Band 0 is not inverted.
- R8: A change of `arr_sel` while enabled takes effect only for the carrier period that starts after the last point of the current period.
- R9: `period_stb` is high for one cycle per carrier period, on the output sample computed from the first carrier point.
- R10: `mod_idx` is unsigned with 1.0 = 2^(MI_W-1). At 1.0 the reference peak equals 5·CAR_HALF, the top of the highest band. Values above 1.0 act as 1.0.
- R11: The phase advances by PHASE_INC per enabled cycle over a 2^PW phase circle. The reference is the index-scaled sine of that phase, and each output sample is registered one cycle after the state it is computed from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the block at its start point |
| arr_sel | input | 2 | Carrier arrangement select |
| mod_idx | input | MI_W | Modulation index, 1.0 = 2^(MI_W-1) |
| level | output | LW (4) | Signed level index, -5..+5 |
| period_stb | output | 1 | Carrier period strobe |

## Verification
The bench builds the block with CAR_HALF = 32, a 16-bit phase circle stepped by 32 and a 256-entry quarter table. With these values a carrier period lasts 64 cycles and a whole fundamental lasts 2048 cycles. Every arrangement, both output extremes and mid-run arrangement changes therefore fit in a short run. The bench models the reference with an ideal sine. Samples where the reference lies within a few units of any carrier are not compared, so table quantisation cannot flip a comparison. The fine table keeps those skipped windows narrow.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

    typedef enum logic [1:0] {
        ARR_ALIGNED  = 2'b00,
        ARR_SPLIT    = 2'b01,
        ARR_ALTERN   = 2'b10,
        ARR_SPARE    = 2'b11
    } arr_mode_e;

    // Fixed-point pi in Q28
    localparam longint PI_Q28 = 64'sd843314857;

    // Quarter-wave sine sample at the centre of slot idx out of n, scaled to 2^w-1
    function automatic int qsine(input int idx, input int n, input int w);
        longint x;
        longint x2;
        longint term;
        longint sum;
        x    = (longint'(2 * idx + 1) * PI_Q28) / longint'(4 * n);
        x2   = (x * x) >>> 28;
        term = x;
        sum  = x;
        for (int j = 1; j <= 6; j++) begin
            term = -(((term * x2) >>> 28) / longint'((2 * j) * (2 * j + 1)));
            sum  = sum + term;
        end
        if (sum < 0) sum = 0;
        return int'((sum * ((longint'(1) << w) - 1)) >>> 28);
    endfunction

    // Whether band k runs the inverted triangle under arrangement m
    function automatic logic band_inverted(input arr_mode_e m, input int k, input int half_n);
        case (m)
            ARR_SPLIT:  return (k < half_n);
            ARR_ALTERN: return (k % 2) == 1;
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/lsp_phase_gen.sv
module lsp_phase_gen #(
    parameter int PW        = 32,
    parameter int PHASE_INC = 2147,
    parameter int TBL_AW    = 8,
    parameter int TBL_W     = 12,
    parameter int MI_W      = 8,
    parameter int PEAK      = 5000,
    parameter int RW        = 14
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [MI_W-1:0]      mod_idx,
    output logic signed [RW-1:0] ref_o
);
    localparam int QN     = 1 << TBL_AW;
    localparam int MI_ONE = 1 << (MI_W - 1);
    localparam int PRW    = TBL_W + MI_W + $clog2(PEAK + 1);
    localparam int SH     = TBL_W + MI_W - 1;

    logic [PW-1:0]     phase_q;
    logic [TBL_W-1:0]  qtab [QN];
    logic [1:0]        quad;
    logic [TBL_AW-1:0] slot;
    logic [TBL_AW-1:0] addr;
    logic [MI_W-1:0]   mi_sat;
    logic [PRW-1:0]    prod;
    logic [PRW-1:0]    scaled;
    logic [RW-1:0]     mag;

    for (genvar i = 0; i < QN; i++) begin : g_tab
        assign qtab[i] = TBL_W'(lsp_pkg::qsine(i, QN, TBL_W));
    end

    always_ff @(posedge clk) begin
        if (rst || !en) phase_q <= '0;
        else            phase_q <= phase_q + PW'(PHASE_INC);
    end

    always_comb begin
        quad   = phase_q[PW-1 -: 2];
        slot   = phase_q[PW-3 -: TBL_AW];
        addr   = quad[0] ? ~slot : slot;
        mi_sat = (mod_idx > MI_W'(MI_ONE)) ? MI_W'(MI_ONE) : mod_idx;
        prod   = PRW'(qtab[addr]) * PRW'(mi_sat) * PRW'(PEAK);
        scaled = prod >> SH;
        mag    = scaled[RW-1:0];
        ref_o  = quad[1] ? -$signed(mag) : $signed(mag);
    end

    // R10
    ref_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(ref_o) <= PEAK) && (int'(ref_o) >= -PEAK));

endmodule

// File: rtl/lsp_carrier_gen.sv
module lsp_carrier_gen #(
    parameter int CAR_HALF = 1000,
    parameter int CW       = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  lsp_pkg::arr_mode_e mode_sel,
    output logic [CW-1:0]      tri_o,
    output lsp_pkg::arr_mode_e mode_o,
    output logic               first_o
);
    import lsp_pkg::*;

    localparam int LAST = 2 * CAR_HALF - 1;

    logic [CW-1:0] pos_q;
    arr_mode_e     mode_q;
    logic          at_last;

    assign at_last = (pos_q == CW'(LAST));

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            mode_q <= ARR_ALIGNED;
        end else if (!en) begin
            pos_q  <= '0;
            mode_q <= mode_sel;
        end else begin
            pos_q <= at_last ? '0 : pos_q + 1'b1;
            if (at_last) mode_q <= mode_sel;
        end
    end

    always_comb begin
        tri_o   = (pos_q < CW'(CAR_HALF)) ? pos_q : CW'(2 * CAR_HALF) - pos_q;
        first_o = (pos_q == '0);
        mode_o  = mode_q;
    end

    // R4
    tri_peak_chk: assert property (@(posedge clk) disable iff (rst)
        tri_o <= CW'(CAR_HALF));

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !at_last) |=> $stable(mode_q));

endmodule

// File: rtl/lsp_band_cmp.sv
module lsp_band_cmp #(
    parameter int HALF_N   = 5,
    parameter int CAR_HALF = 1000,
    parameter int RW       = 14,
    parameter int CW       = 11,
    parameter int LW       = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [RW-1:0] ref_i,
    input  logic [CW-1:0]        tri_i,
    input  lsp_pkg::arr_mode_e   mode_i,
    output logic signed [LW-1:0] level_o
);
    localparam int NC = 2 * HALF_N;

    logic [NC-1:0] hit;

    for (genvar k = 0; k < NC; k++) begin : g_band
        int   car;
        logic inv;
        always_comb begin
            inv = lsp_pkg::band_inverted(mode_i, k, HALF_N);
            car = (k - HALF_N) * CAR_HALF + (inv ? CAR_HALF - int'(tri_i) : int'(tri_i));
            if (k >= HALF_N) hit[k] = int'(ref_i) > car;
            else             hit[k] = int'(ref_i) < car;
        end
    end

    always_comb begin
        level_o = LW'($countones(hit[NC-1:HALF_N])) - LW'($countones(hit[HALF_N-1:0]));
    end

    // R3
    sign_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !((|hit[NC-1:HALF_N]) && (|hit[HALF_N-1:0])));

endmodule

// File: rtl/lsp_modulator.sv
module lsp_modulator #(
    parameter int NLEV      = 11,
    parameter int CAR_HALF  = 1000,
    parameter int PW        = 32,
    parameter int PHASE_INC = 2147,
    parameter int TBL_AW    = 8,
    parameter int TBL_W     = 12,
    parameter int MI_W      = 8,
    localparam int HALF_N   = (NLEV - 1) / 2,
    localparam int LW       = $clog2(HALF_N + 1) + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [1:0]           arr_sel,
    input  logic [MI_W-1:0]      mod_idx,
    output logic signed [LW-1:0] level,
    output logic                 period_stb
);
    import lsp_pkg::*;

    localparam int PEAK = HALF_N * CAR_HALF;
    localparam int RW   = $clog2(PEAK + 1) + 1;
    localparam int CW   = $clog2(2 * CAR_HALF + 1);

    typedef struct packed {
        logic signed [LW-1:0] lvl;
        logic                 stb;
    } out_reg_t;

    logic signed [RW-1:0] ref_s;
    logic [CW-1:0]        tri_s;
    arr_mode_e            mode_s;
    logic                 first_s;
    logic signed [LW-1:0] lvl_s;
    out_reg_t             out_q;

    lsp_phase_gen #(
        .PW(PW), .PHASE_INC(PHASE_INC), .TBL_AW(TBL_AW), .TBL_W(TBL_W),
        .MI_W(MI_W), .PEAK(PEAK), .RW(RW)
    ) u_phase (
        .clk(clk), .rst(rst), .en(en), .mod_idx(mod_idx), .ref_o(ref_s)
    );

    lsp_carrier_gen #(.CAR_HALF(CAR_HALF), .CW(CW)) u_carrier (
        .clk(clk), .rst(rst), .en(en), .mode_sel(arr_mode_e'(arr_sel)),
        .tri_o(tri_s), .mode_o(mode_s), .first_o(first_s)
    );

    lsp_band_cmp #(
        .HALF_N(HALF_N), .CAR_HALF(CAR_HALF), .RW(RW), .CW(CW), .LW(LW)
    ) u_cmp (
        .clk(clk), .rst(rst), .ref_i(ref_s), .tri_i(tri_s), .mode_i(mode_s),
        .level_o(lvl_s)
    );

    always_ff @(posedge clk) begin
        if (rst || !en) out_q <= '0;
        else            out_q <= '{lvl: lvl_s, stb: first_s};
    end

    assign level      = out_q.lvl;
    assign period_stb = out_q.stb;

    // R3
    level_span_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(level) <= HALF_N) && (int'(level) >= -HALF_N));

    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (level == '0) && !period_stb);

    // R9
    stb_single_chk: assert property (@(posedge clk) disable iff (rst)
        period_stb |=> !period_stb);

endmodule

// File: tb/lsp_modulator_test.sv
module lsp_modulator_test;
    localparam int H     = 32;
    localparam int PER   = 2 * H;
    localparam int PWB   = 16;
    localparam int INC   = 32;
    localparam int HN    = 5;
    localparam real PK   = 160.0;
    localparam real TOL  = 3.0;

    logic              clk = 0;
    logic              rst = 1;
    logic              en = 0;
    logic [1:0]        arr_sel = 0;
    logic [7:0]        mod_idx = 0;
    logic signed [3:0] level;
    logic              period_stb;

    int n_chk = 0, n_fail = 0;
    int m_acc = 0, m_p = 0, m_mode = 0;
    int lv_max = 0, lv_min = 0, stb_cnt = 0;
    bit finished = 0;

    lsp_modulator #(
        .NLEV(11), .CAR_HALF(H), .PW(PWB), .PHASE_INC(INC),
        .TBL_AW(8), .TBL_W(12), .MI_W(8)
    ) uut (
        .clk(clk), .rst(rst), .en(en), .arr_sel(arr_sel), .mod_idx(mod_idx),
        .level(level), .period_stb(period_stb)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Ideal level from the requirements: sine reference vs stacked triangles
    function automatic void ideal(input int acc, input int p, input int mode, input int mi,
                                  output int lvl, output bit amb);
        real th, r, car;
        int  c, miv;
        bit  inv;
        miv = (mi > 128) ? 128 : mi;
        th  = 2.0 * 3.14159265358979 * real'(acc) / 65536.0;
        r   = PK * real'(miv) / 128.0 * $sin(th);
        c   = (p < H) ? p : PER - p;
        lvl = 0;
        amb = 0;
        for (int k = 0; k < 2 * HN; k++) begin
            inv = (mode == 1) ? (k < HN) : (mode == 2) ? (k % 2 == 1) : 1'b0;
            car = real'((k - HN) * H + (inv ? H - c : c));
            if ((r - car <= TOL) && (car - r <= TOL)) amb = 1;
            if (k >= HN && r > car) lvl++;
            if (k < HN && r < car) lvl--;
        end
    endfunction

    // One clock: predict from model state, advance model, sample away from the edge
    task automatic tick(input string req);
        int e_lvl;
        bit amb;
        bit e_stb;
        if (en) begin
            ideal(m_acc, m_p, m_mode, int'(mod_idx), e_lvl, amb);
            e_stb = (m_p == 0);
            if (m_p == PER - 1) m_mode = int'(arr_sel);
            m_acc = (m_acc + INC) % 65536;
            m_p   = (m_p + 1) % PER;
        end else begin
            e_lvl = 0; amb = 0; e_stb = 0;
            m_acc = 0; m_p = 0; m_mode = int'(arr_sel);
        end
        @(posedge clk);
        @(negedge clk);
        check(period_stb == e_stb, {"R9 strobe ", req}, int'(period_stb), int'(e_stb));
        if (period_stb) stb_cnt++;
        if (!amb) check(int'(level) == e_lvl, req, int'(level), e_lvl);
        if (int'(level) > lv_max) lv_max = int'(level);
        if (int'(level) < lv_min) lv_min = int'(level);
    endtask

    task automatic restart(input int sel, input int mi);
        en = 0; arr_sel = 2'(sel); mod_idx = 8'(mi);
        tick("R2 restart");
        en = 1;
        lv_max = 0; lv_min = 0; stb_cnt = 0;
    endtask

    task automatic t_reset;
        rst = 1;
        repeat (3) @(negedge clk);
        check(level == 0, "R1 level", int'(level), 0);
        check(period_stb == 0, "R1 strobe", int'(period_stb), 0);
        rst = 0;
        m_acc = 0; m_p = 0; m_mode = 0;
    endtask

    task automatic t_idle;
        en = 0; arr_sel = 2'b01; mod_idx = 8'd128;
        for (int i = 0; i < 100; i++) tick("R2 idle");
    endtask

    task automatic t_aligned;
        restart(0, 128);
        for (int i = 0; i < 2048; i++) tick("R5 R3 R11 aligned");
        check(lv_max == 5, "R3 R10 top level", lv_max, 5);
        check(lv_min == -5, "R3 R10 bottom level", lv_min, -5);
    endtask

    task automatic t_split;
        restart(1, 128);
        for (int i = 0; i < 2048; i++) tick("R6 split");
    endtask

    task automatic t_altern;
        restart(2, 77);
        for (int i = 0; i < 2048; i++) tick("R7 alternate");
    endtask

    task automatic t_low_index;
        restart(0, 26);
        for (int i = 0; i < 2048; i++) tick("R10 low index");
        check(lv_max <= 1 && lv_min >= -1, "R10 low index span", lv_max, 1);
    endtask

    task automatic t_saturate;
        restart(1, 255);
        for (int i = 0; i < 2048; i++) tick("R10 saturation");
        check(lv_max == 5, "R10 saturation peak", lv_max, 5);
    endtask

    task automatic t_spare;
        restart(3, 128);
        for (int i = 0; i < 1024; i++) tick("R5 spare code");
    endtask

    task automatic t_switch;
        restart(0, 128);
        for (int i = 0; i < 2048; i++) begin
            if (i % 37 == 20) arr_sel = 2'((int'(arr_sel) + 1) % 3);
            tick("R8 mid-period change");
        end
    endtask

    task automatic t_strobe;
        restart(2, 100);
        for (int i = 0; i < 10 * PER; i++) tick("R4 carrier period");
        check(stb_cnt == 10, "R9 R4 strobes per 10 periods", stb_cnt, 10);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_idle();
        t_aligned();
        t_split();
        t_altern();
        t_low_index();
        t_saturate();
        t_spare();
        t_switch();
        t_strobe();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule